// File: doc/BRIEF.md
# I2C Master Byte Engine

This block drives a two-wire serial bus as a master, one byte at a time, under software control through four byte-wide registers. Software loads a byte into the data register and writes a master mode with the start bit into the status register. The engine then issues a START, shifts the byte out MSB first, samples the acknowledge bit, and sets a pending flag. While that flag is set the engine holds SCL low and the bus is frozen. Software reads or writes the data register and then clears the flag to release the next byte. It can also arm a STOP or a repeated START beforehand, and clearing the flag then carries that out.

The bit rate comes from two dividers in series. The first divides the input clock by 16 or by 512. The second divides by a 4-bit value plus one. Both bus lines are open-drain: an output enable of 1 pulls the line low. SDA is read back through a synchronizer. SCL is never read back, because this master does not support clock stretching by slaves. A synchronous reset clears every register to zero, which leaves the engine in the slave-receive state with both lines released.

Top module: `i2cb_master`

## Requirements
- R1: After reset, all four registers read 0x00 (address 0 = control, 1 = status, 2 = own address, 3 = data), both line enables are 0, and irq is 0.
- R2: A status write with bits 7:6 = 11 or 10, bit 5 = 1 and bit 4 = 1 while idle produces a START, in which SDA falls while SCL is high. Status bit 5 (busy) then reads 1. The first byte sent is the data register, and it is sent even in mode 10.
- R3: Bytes are sent MSB first. After the 9th (acknowledge) clock falls, control bit 4 (pending) sets. SCL then stays low until control is written with bit 4 = 0.
- R4: Status bit 0 reads 1 if the last transmitted byte was not acknowledged, and 0 if it was.
- R5: In mode 10, the bytes after the address are received MSB first. The received byte reads from the data register once pending sets. The master drives ACK on the 9th clock if control bit 7 is 1, and NACK if it is 0.
- R6: A status write with bit 5 = 0 while busy arms a STOP. The STOP runs when pending is cleared: SDA rises while SCL is high, and busy then reads 0.
- R7: A status write with bit 5 = 1 while busy arms a repeated START. When pending is cleared, the engine issues a new START and sends the data register as the next byte.
- R8: The SCL period is P × (N+1) input clocks. N is control bits 3:0. P is 16 when control bit 6 is 0 and 512 when it is 1.
- R9: irq is 1 exactly while pending is set and control bit 5 is 1.
- R10: A status write with mode 00, or with bit 4 = 0, starts nothing: both lines stay released and busy stays 0.
- R11: A data register write while a byte is shifting is ignored. The byte on the wire and the value read back afterwards are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 own address, 3 data |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Transfer interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Level sensed on the SDA line |

## Verification
A bus slave model in the bench decodes START, STOP, bytes and acknowledges from the line levels. It answers in three patterns, and each one separates different faults:
- A write with every byte acknowledged, against an address that is refused: this checks the no-acknowledge status bit.
- A read whose last byte software answers with NACK: this checks that ACK generation follows the control bit.
- A write followed by a repeated START into a read: this checks the repeated START path against the plain START and the STOP.

The SCL period is measured at two divider settings, one on each prescaler. The hold check waits far longer than one bit time while pending is set, to confirm SCL does not move.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    localparam int DIV_W  = 4;
    localparam int BYTE_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_OWN  = 2'd2;
    localparam logic [1:0] ADDR_DATA = 2'd3;

    localparam logic [1:0] MODE_MT = 2'b11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BITS,
        ST_HOLD,
        ST_STOP
    } state_e;

    typedef struct packed {
        state_e            st;
        logic [2:0]        ph;
        logic [3:0]        bitn;
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] own;
        logic              ackgen;
        logic              presel;
        logic              ien;
        logic              pend;
        logic [DIV_W-1:0]  div;
        logic [1:0]        mode;
        logic              busy;
        logic              txen;
        logic              nack;
        logic              stop_arm;
        logic              rs_arm;
        logic              first;
        logic              scl_oe;
        logic              sda_oe;
    } eng_t;

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
    parameter int PRE_LO = 16,
    parameter int PRE_HI = 512,
    parameter int DIV_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             presel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int Q_LO = PRE_LO / 4;
    localparam int Q_HI = PRE_HI / 4;
    localparam int PC_W = $clog2(Q_HI);

    typedef struct packed {
        logic [PC_W-1:0]  pcnt;
        logic [DIV_W-1:0] dcnt;
    } cnt_t;

    cnt_t c_d, c_q;
    logic [PC_W-1:0] lim;
    logic pwrap;

    always_comb begin
        c_d   = c_q;
        lim   = presel ? PC_W'(Q_HI - 1) : PC_W'(Q_LO - 1);
        pwrap = (c_q.pcnt == lim);
        tick  = run && pwrap && (c_q.dcnt == div);
        if (!run) begin
            c_d = '0;
        end else if (pwrap) begin
            c_d.pcnt = '0;
            c_d.dcnt = (c_q.dcnt == div) ? '0 : c_q.dcnt + 1'b1;
        end else begin
            c_d.pcnt = c_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    // R8: a quarter bit always spans at least two input clocks
    a_r8_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/i2cb_master.sv
module i2cb_master
    import i2cb_pkg::*;
#(
    parameter int PRE_LO      = 16,
    parameter int PRE_HI      = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wen,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        irq,
    output logic        scl_oe,
    output logic        sda_oe,
    input  logic        sda_in
);
    eng_t r, n;
    logic tick, sda_s, run, tx;

    i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
    );

    assign run = (r.st == ST_START) || (r.st == ST_BITS) || (r.st == ST_STOP);

    i2cb_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(run), .presel(r.presel),
        .div(r.div), .tick(tick)
    );

    always_comb begin
        n  = r;
        tx = r.first || (r.mode == MODE_MT);
        if (tick) begin
            case (r.st)
                ST_START: begin
                    n.ph = r.ph + 3'd1;
                    case (r.ph)
                        3'd1: n.scl_oe = 1'b0;
                        3'd3: n.sda_oe = 1'b1;
                        3'd5: begin
                            n.scl_oe = 1'b1;
                            n.st     = ST_BITS;
                            n.ph     = '0;
                            n.bitn   = '0;
                        end
                        default: ;
                    endcase
                end
                ST_BITS: begin
                    n.ph = r.ph + 3'd1;
                    case (r.ph)
                        3'd0: begin
                            if (r.bitn == 4'd8) n.sda_oe = tx ? 1'b0 : r.ackgen;
                            else                n.sda_oe = tx ? ~r.data[7] : 1'b0;
                        end
                        3'd1: n.scl_oe = 1'b0;
                        3'd2: begin
                            if (r.bitn == 4'd8) begin
                                if (tx) n.nack = sda_s;
                            end else begin
                                n.data = {r.data[6:0], sda_s};
                            end
                        end
                        default: begin
                            n.scl_oe = 1'b1;
                            n.ph     = '0;
                            if (r.bitn == 4'd8) begin
                                n.st    = ST_HOLD;
                                n.pend  = 1'b1;
                                n.first = 1'b0;
                            end else begin
                                n.bitn = r.bitn + 4'd1;
                            end
                        end
                    endcase
                end
                ST_STOP: begin
                    n.ph = r.ph + 3'd1;
                    case (r.ph)
                        3'd1: n.scl_oe = 1'b0;
                        3'd3: n.sda_oe = 1'b0;
                        3'd5: begin
                            n.st   = ST_IDLE;
                            n.ph   = '0;
                            n.busy = 1'b0;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end

        if (reg_wen) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    n.ackgen = reg_wdata[7];
                    n.presel = reg_wdata[6];
                    n.ien    = reg_wdata[5];
                    n.div    = reg_wdata[DIV_W-1:0];
                    if (!reg_wdata[4] && r.pend) begin
                        n.pend = 1'b0;
                        n.ph   = '0;
                        if (r.stop_arm) begin
                            n.st       = ST_STOP;
                            n.sda_oe   = 1'b1;
                            n.stop_arm = 1'b0;
                        end else if (r.rs_arm) begin
                            n.st     = ST_START;
                            n.sda_oe = 1'b0;
                            n.first  = 1'b1;
                            n.rs_arm = 1'b0;
                        end else begin
                            n.st   = ST_BITS;
                            n.bitn = '0;
                        end
                    end
                end
                ADDR_STAT: begin
                    n.mode = reg_wdata[7:6];
                    n.txen = reg_wdata[4];
                    if (reg_wdata[7] && reg_wdata[4]) begin
                        if (reg_wdata[5] && r.st == ST_IDLE) begin
                            n.st     = ST_START;
                            n.ph     = '0;
                            n.busy   = 1'b1;
                            n.first  = 1'b1;
                            n.sda_oe = 1'b0;
                        end else if (r.busy) begin
                            n.rs_arm   = reg_wdata[5];
                            n.stop_arm = ~reg_wdata[5];
                        end
                    end
                end
                ADDR_OWN: n.own = reg_wdata;
                default: begin
                    if (r.st != ST_BITS) n.data = reg_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= n;
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {r.ackgen, r.presel, r.ien, r.pend, r.div};
            ADDR_STAT: reg_rdata = {r.mode, r.busy, r.txen, 3'b000, r.nack};
            ADDR_OWN:  reg_rdata = r.own;
            default:   reg_rdata = r.data;
        endcase
    end

    assign irq    = r.pend & r.ien;
    assign scl_oe = r.scl_oe;
    assign sda_oe = r.sda_oe;

    // R3: the bus is frozen with SCL low while a byte is pending
    a_r3_hold_low: assert property (@(posedge clk) disable iff (rst)
        r.pend |-> r.scl_oe);
    // R3: pending only rises at the end of a shifted byte
    a_r3_pend_src: assert property (@(posedge clk) disable iff (rst)
        $rose(r.pend) |-> $past(r.st == ST_BITS));
    // R2: SDA is only pulled with SCL high once the bus is owned
    a_r2_start_owned: assert property (@(posedge clk) disable iff (rst)
        ($rose(r.sda_oe) && !r.scl_oe) |-> r.busy);
    // R6: an idle bus has both lines released
    a_r6_idle_free: assert property (@(posedge clk) disable iff (rst)
        !r.busy |-> (!r.scl_oe && !r.sda_oe));
endmodule

// File: tb/sim_i2cb_master.sv
module sim_i2cb_master;
    logic clk = 1'b0, rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic reg_wen = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_oe, sda_oe, sda_in;
    logic s_low = 1'b0;
    logic scl_l, sda_l;

    always #4 clk = ~clk;

    assign scl_l  = ~scl_oe;
    assign sda_l  = ~(sda_oe | s_low);
    assign sda_in = sda_l;

    i2cb_master u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wen(reg_wen),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    int checks = 0, fails = 0;

    // bus slave model
    int cyc = 0, starts = 0, stops = 0, rises = 0, period = 0, last_rise = 0;
    int bitcnt = 0, ngot = 0, nmack = 0;
    logic first = 0, rd = 0, mack = 0, sending = 0, drive = 0;
    logic ack_addr = 1, ack_data = 1;
    logic scl_p = 1, sda_p = 1, lscl, lsda;
    logic [7:0] sreg = 0, cur = 0, txb = 0;
    logic [7:0] got [0:15];
    logic macks [0:15];

    always @(negedge clk) begin
        cyc++;
        lscl = scl_l;
        lsda = sda_l;
        if (rst) begin
            s_low = 0; bitcnt = 0; sending = 0;
        end else if (lscl && scl_p && sda_p && !lsda) begin
            starts++; bitcnt = 0; first = 1; rd = 0; sending = 0; s_low = 0;
        end else if (lscl && scl_p && !sda_p && lsda) begin
            stops++;
        end else if (lscl && !scl_p) begin
            rises++; period = cyc - last_rise; last_rise = cyc;
            sreg = {sreg[6:0], lsda};
            bitcnt++;
            if (bitcnt == 8 && (first || !rd)) begin
                got[ngot[3:0]] = sreg; ngot++;
                if (first) rd = sreg[0];
            end
            if (bitcnt == 9 && !first && rd) begin
                mack = !lsda; macks[nmack[3:0]] = !lsda; nmack++;
            end
        end else if (!lscl && scl_p) begin
            if (bitcnt == 8) begin
                sending = 0;
                s_low = (first || !rd) ? (first ? ack_addr : ack_data) : 1'b0;
            end else if (bitcnt == 9) begin
                bitcnt = 0;
                drive = rd && (first ? ack_addr : mack);
                first = 0;
                sending = drive;
                if (drive) begin
                    cur = txb; txb = txb + 8'h11; s_low = !cur[7];
                end else s_low = 0;
            end else if (bitcnt >= 1 && bitcnt <= 7 && sending) begin
                s_low = !cur[7 - bitcnt];
            end
        end
        scl_p = lscl;
        sda_p = lsda;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rdr(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_pend(input string tag);
        logic [7:0] v = 0;
        for (int i = 0; i < 20000; i++) begin
            rdr(2'd0, v);
            if (v[4]) break;
        end
        chk(tag, v[4], 1);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v = 8'hFF;
        for (int i = 0; i < 20000; i++) begin
            rdr(2'd1, v);
            if (!v[5]) break;
        end
        chk(tag, v[5], 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rdr(a[1:0], v);
            chk("R1 register reset", v, 0);
        end
        chk("R1 lines released", {scl_oe, sda_oe, irq}, 0);
    endtask

    task automatic t_write;
        logic [7:0] v;
        int r0;
        ack_addr = 1; ack_data = 1;
        wr(2'd0, 8'hA0);
        wr(2'd3, 8'hA4);
        wr(2'd1, 8'hF0);
        rdr(2'd1, v);
        chk("R2 busy after start", v, 8'hF0);
        wait_pend("R3 pending after address");
        chk("R2 start seen", starts, 1);
        chk("R2 address byte", got[0], 8'hA4);
        chk("R9 irq with enable", irq, 1);
        rdr(2'd0, v);
        chk("R3 control shows pending", v, 8'hB0);
        r0 = rises;
        repeat (400) @(negedge clk);
        chk("R3 no SCL rise while pending", rises, r0);
        chk("R3 SCL held low", scl_l, 0);
        wr(2'd3, 8'h3C);
        wr(2'd0, 8'hA0);
        wait_pend("R3 pending after data");
        chk("R3 data byte msb first", got[1], 8'h3C);
        rdr(2'd1, v);
        chk("R4 acked byte", v[0], 0);
        wr(2'd3, 8'h5A);
        wr(2'd0, 8'hA0);
        repeat (20) @(negedge clk);
        wr(2'd3, 8'hFF);
        wait_pend("R11 pending");
        chk("R11 wire byte unchanged", got[2], 8'h5A);
        rdr(2'd3, v);
        chk("R11 data register unchanged", v, 8'h5A);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA0);
        wait_idle("R6 busy clears");
        chk("R6 stop seen", stops, 1);
        chk("R6 lines released", {scl_oe, sda_oe}, 0);
    endtask

    task automatic t_nack;
        logic [7:0] v;
        ack_addr = 0;
        wr(2'd0, 8'h80);
        wr(2'd3, 8'h90);
        wr(2'd1, 8'hF0);
        wait_pend("R4 pending");
        rdr(2'd1, v);
        chk("R4 nack status", v, 8'hF1);
        chk("R9 irq masked", irq, 0);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'h80);
        wait_idle("R6 idle after nack");
        ack_addr = 1;
    endtask

    task automatic t_read;
        logic [7:0] v;
        int m0;
        txb = 8'h3C;
        m0 = nmack;
        wr(2'd0, 8'hA0);
        wr(2'd3, 8'hA5);
        wr(2'd1, 8'hB0);
        wait_pend("R2 address in receive mode");
        chk("R2 read address byte", got[ngot - 1], 8'hA5);
        rdr(2'd1, v);
        chk("R5 status in receive", v, 8'hB0);
        wr(2'd0, 8'hA0);
        wait_pend("R5 pending rx1");
        rdr(2'd3, v);
        chk("R5 first received byte", v, 8'h3C);
        wr(2'd0, 8'h20);
        wait_pend("R5 pending rx2");
        rdr(2'd3, v);
        chk("R5 second received byte", v, 8'h4D);
        chk("R5 ack driven", macks[m0[3:0]], 1);
        chk("R5 nack driven", macks[(m0 + 1) & 15], 0);
        wr(2'd1, 8'h90);
        wr(2'd0, 8'h20);
        wait_idle("R6 idle after read");
    endtask

    task automatic t_restart;
        logic [7:0] v;
        int s0;
        s0 = starts;
        txb = 8'h61;
        wr(2'd0, 8'hA0);
        wr(2'd3, 8'hA4);
        wr(2'd1, 8'hF0);
        wait_pend("R7 pending a");
        wr(2'd3, 8'h10);
        wr(2'd0, 8'hA0);
        wait_pend("R7 pending b");
        wr(2'd3, 8'hA5);
        wr(2'd1, 8'hB0);
        wr(2'd0, 8'hA0);
        wait_pend("R7 pending c");
        chk("R7 repeated start seen", starts, s0 + 2);
        chk("R7 address after restart", got[(ngot - 1) & 15], 8'hA5);
        wr(2'd0, 8'h20);
        wait_pend("R7 pending d");
        rdr(2'd3, v);
        chk("R7 byte after restart", v, 8'h61);
        wr(2'd1, 8'h90);
        wr(2'd0, 8'h20);
        wait_idle("R7 idle");
    endtask

    task automatic t_clock;
        wr(2'd0, 8'hA2);
        wr(2'd3, 8'hA4);
        wr(2'd1, 8'hF0);
        wait_pend("R8 pending n2");
        chk("R8 period 16x3", period, 48);
        wr(2'd3, 8'h77);
        wr(2'd0, 8'hE0);
        wait_pend("R8 pending p512");
        chk("R8 period 512x1", period, 512);
        wr(2'd1, 8'hD0);
        wr(2'd0, 8'hA0);
        wait_idle("R8 idle");
    endtask

    task automatic t_ignore;
        logic [7:0] v;
        int s0;
        s0 = starts;
        wr(2'd1, 8'h30);
        repeat (200) @(negedge clk);
        wr(2'd1, 8'hE0);
        repeat (200) @(negedge clk);
        chk("R10 no start", starts, s0);
        chk("R10 lines released", {scl_l, sda_l}, 2'b11);
        rdr(2'd1, v);
        chk("R10 not busy", v[5], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_write;
        t_nack;
        t_read;
        t_restart;
        t_clock;
        t_ignore;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule